// File: doc/BRIEF.md
# Cell Balancing Switch Controller

This block drives up to sixteen passive cell-balancing switch outputs from a host-written enable mask. Every set mask bit turns on the matching output. An optional balance timer, set through a configuration write, clears the whole mask once a programmed number of timer ticks has passed. A fault vector can cancel balancing. A policy bit in the configuration selects whether faults clear the mask or are ignored. A separate checksum-fault input never cancels balancing.

Each change of the mask produces a one-cycle checksum-event pulse, so that a configuration integrity monitor elsewhere knows that its stored signature is stale. A squeeze input, used while open-wire diagnostics run, forces every output off and keeps the mask. Balancing resumes when squeeze is released. All outputs are registered, and all state uses one synchronous active-high reset.

Top module: `cell_bal_ctrl`

## Requirements
- R1: With squeeze low, `bal_drv[i]` equals mask bit i. A mask write is visible on `mask_rd` and `bal_drv` at the first rising edge after the cycle in which `mask_wr_en` is sampled high.
- R2: With `cont_rd` = 0, any set bit of `flt_in` sampled at an edge clears the mask at that edge. This takes priority over a mask write in the same cycle. The mask stays zero until the next mask write made while no fault is present.
- R3: `csum_flt` never changes the mask, whatever the policy bit.
- R4: Neither a fault cancel nor a timer expiry changes `cfg_time_rd` or `cont_rd`. Only a configuration write (`cfg_wr_en`) updates them, at the next edge.
- R5: With `cont_rd` = 1, `flt_in` has no effect on the mask, the timer or the outputs.
- R6: With balance time T > 0, a mask write loads the timer with T. The timer counts ticks sampled on later cycles, and the mask clears on the T-th such tick. A new mask write restarts the count and takes priority over an expiry in the same cycle. A tick sampled in the same cycle as the write is not counted.
- R7: `csum_evt` is high for exactly the cycle in which `mask_rd` shows a new value, whether the change comes from a write, a fault cancel or an expiry. A write of the value already held raises no event.
- R8: `bal_active` is 1 exactly when at least one mask bit is set, regardless of squeeze.
- R9: While `squeeze_en` is sampled high, `bal_drv` is all zero at the following edge, and the mask is kept. The drives return to the mask one edge after squeeze is sampled low.
- R10: Balance time 0 disables expiry. The mask then holds through any number of ticks.
- R11: After reset, the mask, the drives, `bal_active`, `csum_evt`, `cont_rd` and `cfg_time_rd` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mask_wr_en | input | 1 | Write strobe for the enable mask |
| mask_wr_data | input | N_CELLS | New enable mask |
| cfg_wr_en | input | 1 | Write strobe for the configuration |
| cfg_cont_wr | input | 1 | Continue-on-fault policy bit to be written |
| cfg_time_wr | input | TIME_W | Balance time in ticks to be written (0 = no timeout) |
| flt_in | input | FLT_W | Fault sources that may cancel balancing |
| csum_flt | input | 1 | Checksum fault, exempt from cancel |
| squeeze_en | input | 1 | Open-wire squeeze mode: forces all drives off |
| tick | input | 1 | Balance timer tick strobe |
| bal_drv | output | N_CELLS | Balancing switch drives |
| bal_active | output | 1 | At least one mask bit set |
| csum_evt | output | 1 | One-cycle pulse on any mask change |
| mask_rd | output | N_CELLS | Mask read-back |
| cont_rd | output | 1 | Policy bit read-back |
| cfg_time_rd | output | TIME_W | Balance time read-back |

## Verification
The timer and the write path can act in the same cycle. The bench lines up a mask write with the tick that would otherwise expire the count, and also sends a tick in the cycle of a write. It then judges whether the mask survives and whether the count restarts from full. The fault cancel and a host write can also coincide. The bench asserts a fault together with a write under both policy settings and expects cancel to win only when the policy bit is 0. A behavioural reference model is compared with every output on every cycle.

// File: rtl/cbal_pkg.sv
package cbal_pkg;
  typedef enum logic [1:0] {
    UPD_HOLD   = 2'd0,
    UPD_CANCEL = 2'd1,
    UPD_WRITE  = 2'd2,
    UPD_EXPIRE = 2'd3
  } upd_e;
endpackage

// File: rtl/cbal_timer.sv
module cbal_timer #(
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              clear,
  input  logic              tick,
  input  logic [TIME_W-1:0] load_val,
  output logic              expire
);
  localparam logic [TIME_W-1:0] ONE = TIME_W'(1);

  logic [TIME_W-1:0] cnt_q;

  // Expiry is only reported when neither cancel nor write preempts it
  assign expire = tick && (cnt_q == ONE) && !load && !clear;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick && cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/cbal_mask_reg.sv
module cbal_mask_reg
  import cbal_pkg::*;
#(
  parameter int N_CELLS = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  upd_e               upd,
  input  logic [N_CELLS-1:0] wr_data,
  output logic [N_CELLS-1:0] mask_next,
  output logic [N_CELLS-1:0] mask_q,
  output logic               evt_q,
  output logic               active_q
);
  always_comb begin
    unique case (upd)
      UPD_CANCEL: mask_next = '0;
      UPD_EXPIRE: mask_next = '0;
      UPD_WRITE:  mask_next = wr_data;
      default:    mask_next = mask_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      evt_q    <= 1'b0;
      active_q <= 1'b0;
    end else begin
      mask_q   <= mask_next;
      evt_q    <= (mask_next != mask_q);
      active_q <= |mask_next;
    end
  end
endmodule

// File: rtl/cbal_drive.sv
module cbal_drive #(
  parameter int N_CELLS = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               squeeze,
  input  logic [N_CELLS-1:0] mask_next,
  output logic [N_CELLS-1:0] drv_q
);
  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) drv_q[i] <= 1'b0;
      else     drv_q[i] <= mask_next[i] & ~squeeze;
    end
  end
endmodule

// File: rtl/cell_bal_ctrl.sv
module cell_bal_ctrl
  import cbal_pkg::*;
#(
  parameter int N_CELLS = 16,
  parameter int TIME_W  = 8,
  parameter int FLT_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mask_wr_en,
  input  logic [N_CELLS-1:0] mask_wr_data,
  input  logic               cfg_wr_en,
  input  logic               cfg_cont_wr,
  input  logic [TIME_W-1:0]  cfg_time_wr,
  input  logic [FLT_W-1:0]   flt_in,
  input  logic               csum_flt,
  input  logic               squeeze_en,
  input  logic               tick,
  output logic [N_CELLS-1:0] bal_drv,
  output logic               bal_active,
  output logic               csum_evt,
  output logic [N_CELLS-1:0] mask_rd,
  output logic               cont_rd,
  output logic [TIME_W-1:0]  cfg_time_rd
);
  logic               cont_q;
  logic [TIME_W-1:0]  time_q;
  logic               cancel;
  logic               expire;
  upd_e               upd;
  logic [N_CELLS-1:0] mask_next;

  // Configuration register: touched only by host configuration writes
  always_ff @(posedge clk) begin
    if (rst) begin
      cont_q <= 1'b0;
      time_q <= '0;
    end else if (cfg_wr_en) begin
      cont_q <= cfg_cont_wr;
      time_q <= cfg_time_wr;
    end
  end

  // Checksum fault deliberately not part of the cancel term
  assign cancel = !cont_q && (|flt_in);

  always_comb begin
    if (cancel)          upd = UPD_CANCEL;
    else if (mask_wr_en) upd = UPD_WRITE;
    else if (expire)     upd = UPD_EXPIRE;
    else                 upd = UPD_HOLD;
  end

  cbal_timer #(.TIME_W(TIME_W)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (mask_wr_en),
    .clear    (cancel),
    .tick     (tick),
    .load_val (time_q),
    .expire   (expire)
  );

  cbal_mask_reg #(.N_CELLS(N_CELLS)) mask_i (
    .clk       (clk),
    .rst       (rst),
    .upd       (upd),
    .wr_data   (mask_wr_data),
    .mask_next (mask_next),
    .mask_q    (mask_rd),
    .evt_q     (csum_evt),
    .active_q  (bal_active)
  );

  cbal_drive #(.N_CELLS(N_CELLS)) drive_i (
    .clk       (clk),
    .rst       (rst),
    .squeeze   (squeeze_en),
    .mask_next (mask_next),
    .drv_q     (bal_drv)
  );

  assign cont_rd     = cont_q;
  assign cfg_time_rd = time_q;
endmodule

// File: rtl/cbal_chk.sv
module cbal_chk #(
  parameter int N_CELLS = 16,
  parameter int TIME_W  = 8,
  parameter int FLT_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               mask_wr_en,
  input logic               cfg_wr_en,
  input logic [FLT_W-1:0]   flt_in,
  input logic               csum_flt,
  input logic               squeeze_en,
  input logic               tick,
  input logic [N_CELLS-1:0] bal_drv,
  input logic               bal_active,
  input logic               csum_evt,
  input logic [N_CELLS-1:0] mask_rd,
  input logic               cont_rd,
  input logic [TIME_W-1:0]  cfg_time_rd
);
  AST_DRV_FOLLOWS_MASK: assert property (@(posedge clk) disable iff (rst)
    !squeeze_en |=> (bal_drv == mask_rd)); // R1

  AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!cont_rd && (|flt_in)) |=> (mask_rd == '0)); // R2

  AST_CSUM_EXEMPT: assert property (@(posedge clk) disable iff (rst)
    (csum_flt && flt_in == '0 && !mask_wr_en && !tick) |=> $stable(mask_rd)); // R3

  AST_CFG_KEEP: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr_en |=> ($stable(cfg_time_rd) && $stable(cont_rd))); // R4

  AST_EVT_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (mask_rd != $past(mask_rd)) |-> csum_evt); // R7

  AST_ACTIVE_MATCH: assert property (@(posedge clk) disable iff (rst)
    bal_active == (|mask_rd)); // R8

  AST_SQUEEZE_OFF: assert property (@(posedge clk) disable iff (rst)
    squeeze_en |=> (bal_drv == '0)); // R9
endmodule

bind cell_bal_ctrl cbal_chk #(
  .N_CELLS (N_CELLS),
  .TIME_W  (TIME_W),
  .FLT_W   (FLT_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .mask_wr_en  (mask_wr_en),
  .cfg_wr_en   (cfg_wr_en),
  .flt_in      (flt_in),
  .csum_flt    (csum_flt),
  .squeeze_en  (squeeze_en),
  .tick        (tick),
  .bal_drv     (bal_drv),
  .bal_active  (bal_active),
  .csum_evt    (csum_evt),
  .mask_rd     (mask_rd),
  .cont_rd     (cont_rd),
  .cfg_time_rd (cfg_time_rd)
);

// File: tb/cell_bal_ctrl_tb_top.sv
`timescale 1ns/1ps
module cell_bal_ctrl_tb_top;
  localparam int N = 16;
  localparam int TW = 8;
  localparam int FW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mask_wr_en = 1'b0;
  logic [N-1:0] mask_wr_data = '0;
  logic cfg_wr_en = 1'b0;
  logic cfg_cont_wr = 1'b0;
  logic [TW-1:0] cfg_time_wr = '0;
  logic [FW-1:0] flt_in = '0;
  logic csum_flt = 1'b0;
  logic squeeze_en = 1'b0;
  logic tick = 1'b0;
  logic [N-1:0] bal_drv;
  logic bal_active;
  logic csum_evt;
  logic [N-1:0] mask_rd;
  logic cont_rd;
  logic [TW-1:0] cfg_time_rd;

  always #2.5 clk = ~clk;

  cell_bal_ctrl #(.N_CELLS(N), .TIME_W(TW), .FLT_W(FW)) dut_i (
    .clk(clk), .rst(rst), .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .cfg_wr_en(cfg_wr_en), .cfg_cont_wr(cfg_cont_wr), .cfg_time_wr(cfg_time_wr),
    .flt_in(flt_in), .csum_flt(csum_flt), .squeeze_en(squeeze_en), .tick(tick),
    .bal_drv(bal_drv), .bal_active(bal_active), .csum_evt(csum_evt),
    .mask_rd(mask_rd), .cont_rd(cont_rd), .cfg_time_rd(cfg_time_rd)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R11";

  // Behavioural reference model
  int m_mask = 0;
  int m_cnt = 0;
  int m_cont = 0;
  int m_time = 0;
  int m_drv = 0;
  int m_act = 0;
  int m_evt = 0;

  always @(posedge clk) begin
    int nxt;
    bit cancel;
    if (rst) begin
      m_mask = 0; m_cnt = 0; m_cont = 0; m_time = 0;
      m_drv = 0; m_act = 0; m_evt = 0;
    end else begin
      cancel = (m_cont == 0) && (flt_in != 0);
      nxt = m_mask;
      if (cancel) begin
        nxt = 0; m_cnt = 0;
      end else if (mask_wr_en) begin
        nxt = int'(mask_wr_data); m_cnt = m_time;
      end else if (tick && m_cnt != 0) begin
        if (m_cnt == 1) nxt = 0;
        m_cnt = m_cnt - 1;
      end
      m_evt = (nxt != m_mask) ? 1 : 0;
      m_mask = nxt;
      m_act = (nxt != 0) ? 1 : 0;
      m_drv = squeeze_en ? 0 : nxt;
      if (cfg_wr_en) begin
        m_cont = int'(cfg_cont_wr); m_time = int'(cfg_time_wr);
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  // Compare every output on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("bal_drv", int'(bal_drv), m_drv);
      chk("mask_rd", int'(mask_rd), m_mask);
      chk("bal_active", int'(bal_active), m_act);
      chk("csum_evt", int'(csum_evt), m_evt);
      chk("cont_rd", int'(cont_rd), m_cont);
      chk("cfg_time_rd", int'(cfg_time_rd), m_time);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mask_wr_en = 0; cfg_wr_en = 0; tick = 0;
    end
  endtask

  task automatic wr_mask(int v);
    @(negedge clk);
    mask_wr_en = 1; mask_wr_data = N'(v); cfg_wr_en = 0; tick = 0;
  endtask

  task automatic wr_cfg(int cont, int t);
    @(negedge clk);
    cfg_wr_en = 1; cfg_cont_wr = cont[0]; cfg_time_wr = TW'(t);
    mask_wr_en = 0; tick = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mask_wr_en = 0; cfg_wr_en = 0; tick = 1;
    end
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R11";
    chk("reset mask", int'(mask_rd), 0);
    chk("reset drv", int'(bal_drv), 0);
    chk("reset cfg", int'(cfg_time_rd), 0);

    cur_req = "R1";
    wr_mask(16'hA5C3); idle(1);
    chk("write visible R1", int'(bal_drv), 16'hA5C3);
    wr_mask(16'h0001); idle(2);
    wr_mask(16'h8000); idle(2);

    cur_req = "R7";
    wr_mask(16'h8000); idle(1);
    chk("same-value write no event R7", int'(csum_evt), 0);

    cur_req = "R8";
    wr_mask(0); idle(1);
    chk("all clear inactive R8", int'(bal_active), 0);

    cur_req = "R10";
    wr_mask(16'h00FF); ticks(40); idle(1);
    chk("no timeout held R10", int'(mask_rd), 16'h00FF);

    cur_req = "R6";
    wr_cfg(0, 5); wr_mask(16'h0F0F); ticks(3); idle(2); ticks(1);
    idle(1);
    chk("partial count held R6", int'(mask_rd), 16'h0F0F);
    ticks(1); idle(1);
    chk("expired on fifth tick R6", int'(mask_rd), 0);
    wr_mask(16'h3333); ticks(4);
    @(negedge clk); mask_wr_en = 1; mask_wr_data = 16'h7777; tick = 1;
    idle(1);
    chk("write beats expiry R6", int'(mask_rd), 16'h7777);
    ticks(4); idle(1);
    chk("restart still counting R6", int'(mask_rd), 16'h7777);
    ticks(1); idle(2);

    cur_req = "R2";
    wr_cfg(0, 0); wr_mask(16'hFFFF); idle(2);
    @(negedge clk); flt_in = 4'b0100;
    idle(1);
    chk("fault cleared R2", int'(mask_rd), 0);
    @(negedge clk); mask_wr_en = 1; mask_wr_data = 16'h1234;
    idle(1);
    chk("fault beats write R2", int'(mask_rd), 0);
    flt_in = 0; idle(3);
    chk("stays off R2", int'(mask_rd), 0);
    wr_mask(16'h1234); idle(1);

    cur_req = "R4";
    wr_cfg(0, 9); wr_mask(16'h00F0); idle(1);
    @(negedge clk); flt_in = 4'b0001;
    idle(1); flt_in = 0; idle(1);
    chk("time kept after cancel R4", int'(cfg_time_rd), 9);

    cur_req = "R3";
    wr_cfg(0, 0); wr_mask(16'h5A5A); idle(1);
    csum_flt = 1; idle(4); csum_flt = 0;
    chk("checksum fault exempt R3", int'(mask_rd), 16'h5A5A);

    cur_req = "R5";
    wr_cfg(1, 0); wr_mask(16'hC00C); idle(1);
    @(negedge clk); flt_in = 4'b1111; mask_wr_en = 1; mask_wr_data = 16'h0C30;
    idle(3); flt_in = 0;
    chk("faults ignored R5", int'(mask_rd), 16'h0C30);

    cur_req = "R9";
    @(negedge clk); squeeze_en = 1;
    idle(2);
    chk("squeezed drv R9", int'(bal_drv), 0);
    chk("mask kept R9", int'(mask_rd), 16'h0C30);
    wr_mask(16'h0003); idle(1);
    squeeze_en = 0; idle(1);
    chk("released drv R9", int'(bal_drv), 16'h0003);
    idle(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule